// File: doc/BRIEF.md
# Errored Field Counter with Clear Modes

This block keeps a saturating count of video fields that arrived with errors. Once per field, a one-cycle strobe arrives together with a 15-bit error flag vector and a 15-bit sensitivity mask. The field counts as errored when at least one flag is high and its mask bit is also high. An errored field adds one to the count, however many flags it carries.

A two-bit mode register sets how the count is cleared. There are four modes:
- **Run:** plain counting.
- **One-shot clear:** clears once and then drops back to run by itself.
- **Clear-on-read:** counts, and clears whenever the host reads the count's low byte.
- **Hold-at-zero:** pins the count at zero until another mode is written.

The count is also visible as bytes through a simple read port. The low byte sits at address 17, and the higher bytes sit at the addresses above it.

Top module: `err_field_counter`

## Requirements
- R1: After reset, `count` is 0 and `mode` is 2'b00.
- R2: In mode 2'b00, a cycle with `fieldStrobe` high and `(errFlags & sensMask) != 0` raises `count` by exactly one at the next clock edge, whether one flag or many are set.
- R3: The count does not change in a field whose set flags all have a clear mask bit, nor in any cycle where `fieldStrobe` is low.
- R4: The count saturates at all ones, 24'hFFFFFF at the default width (8'hFF at an 8-bit width), and stays there on further errored fields.
- R5: Writing 2'b01 makes `mode` read 2'b01 for one cycle. At the following edge, `count` becomes 0 and `mode` returns to 2'b00, and counting resumes after that.
- R6: In mode 2'b10, the count counts as in run mode and clears at the edge ending a cycle with `hostRdEn` high and `hostRdAddr` equal to 17. Reads of 18 or 19 do not clear it, and in mode 2'b00 a read of 17 does not clear it.
- R7: When a clearing read and an errored field strobe fall in the same cycle, the count becomes 0 and that field is not counted.
- R8: In mode 2'b11, the count is 0 from the next edge onward and ignores errored fields. Counting resumes once another mode is written.
- R9: `hostRdData` is combinational. Address 17 gives count[7:0], 18 gives count[15:8], 19 gives count[23:16], and any other address gives 8'h00.
- R10: `modeWrEn` loads `modeWrData` into `mode` at the next edge. A write in the cycle where `mode` is 2'b01 takes precedence over the automatic return to 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fieldStrobe | input | 1 | One-cycle pulse marking a field's flag vector as valid |
| errFlags | input | 15 | Error flags for the field |
| sensMask | input | 15 | Sensitivity mask; a set bit lets the matching flag count |
| modeWrEn | input | 1 | Mode register write enable |
| modeWrData | input | 2 | New mode value |
| hostRdEn | input | 1 | Host read access this cycle |
| hostRdAddr | input | 8 | Host read address |
| hostRdData | output | 8 | Selected count byte |
| count | output | 24 | Current errored field count |
| mode | output | 2 | Current clear mode |

## Verification
The hardest state to reach is the saturated count. Reaching 2^24 errored fields is far beyond any run length, so the bench places a second instance with an 8-bit count beside the default one and drives both with the same stimulus, pushing the narrow one past 255 fields. A second tight case is the single cycle in which the one-shot mode is visible. The bench writes a new mode in exactly that cycle, which checks that the write beats the automatic return to run. A third is the same-cycle collision of an errored field and a low-byte read in clear-on-read mode, produced by raising both inputs at one falling edge.

// File: rtl/efc_pkg.sv
package efc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'b00,
    MODE_ONESHOT = 2'b01,
    MODE_RDCLR   = 2'b10,
    MODE_HOLD    = 2'b11
  } efcMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;    // force count to zero this cycle
    logic cntEn;  // errored fields may increment
  } efcStrobe_t;

endpackage

// File: rtl/efc_ctrl.sv
module efc_ctrl
  import efc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int LOW_ADDR = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrEn,
  input  logic [1:0]        modeWrData,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostRdAddr,
  output efcMode_e          modeQ,
  output efcStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] LowAddr = ADDR_W'(LOW_ADDR);

  efcMode_e modeD;
  logic     lowRead;

  assign lowRead = hostRdEn && (hostRdAddr == LowAddr);

  always_comb begin
    modeD = modeQ;
    if (modeWrEn)
      modeD = efcMode_e'(modeWrData);
    else if (modeQ == MODE_ONESHOT)
      modeD = MODE_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_RUN;
    else       modeQ <= modeD;
  end

  always_comb begin
    unique case (modeQ)
      MODE_ONESHOT: strb.clr = 1'b1;
      MODE_HOLD:    strb.clr = 1'b1;
      MODE_RDCLR:   strb.clr = lowRead;
      default:      strb.clr = 1'b0;
    endcase
    strb.cntEn = !strb.clr;
  end

endmodule

// File: rtl/efc_datapath.sv
module efc_datapath
  import efc_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int FLAG_W   = 15,
  parameter int ADDR_W   = 8,
  parameter int LOW_ADDR = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  efcStrobe_t        strb,
  input  logic              fieldStrobe,
  input  logic [FLAG_W-1:0] errFlags,
  input  logic [FLAG_W-1:0] sensMask,
  input  logic [ADDR_W-1:0] hostRdAddr,
  output logic [7:0]        hostRdData,
  output logic [CNT_W-1:0]  countQ
);

  localparam int NBYTES = (CNT_W + 7) / 8;
  localparam int PAD_W  = NBYTES * 8;
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic             fieldHit;
  logic             atMax;
  logic [PAD_W-1:0] countPad;

  assign fieldHit = fieldStrobe && (|(errFlags & sensMask));
  assign atMax    = (countQ == CntMax);

  always_ff @(posedge clk) begin
    if (!rstN)
      countQ <= '0;
    else if (strb.clr)
      countQ <= '0;
    else if (strb.cntEn && fieldHit && !atMax)
      countQ <= countQ + 1'b1;
  end

  assign countPad = PAD_W'(countQ);

  // byte-per-address read mux
  logic [NBYTES-1:0][7:0] byteSel;
  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign byteSel[b] = (hostRdAddr == ADDR_W'(LOW_ADDR + b)) ? countPad[b*8 +: 8] : 8'h00;
    end
  endgenerate

  always_comb begin
    hostRdData = 8'h00;
    for (int b = 0; b < NBYTES; b++) hostRdData |= byteSel[b];
  end

endmodule

// File: rtl/err_field_counter.sv
module err_field_counter
  import efc_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int FLAG_W   = 15,
  parameter int ADDR_W   = 8,
  parameter int LOW_ADDR = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fieldStrobe,
  input  logic [FLAG_W-1:0] errFlags,
  input  logic [FLAG_W-1:0] sensMask,
  input  logic              modeWrEn,
  input  logic [1:0]        modeWrData,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostRdAddr,
  output logic [7:0]        hostRdData,
  output logic [CNT_W-1:0]  count,
  output logic [1:0]        mode
);

  efcMode_e   modeQ;
  efcStrobe_t strb;

  efc_ctrl #(.ADDR_W(ADDR_W), .LOW_ADDR(LOW_ADDR)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeWrEn   (modeWrEn),
    .modeWrData (modeWrData),
    .hostRdEn   (hostRdEn),
    .hostRdAddr (hostRdAddr),
    .modeQ      (modeQ),
    .strb       (strb)
  );

  efc_datapath #(.CNT_W(CNT_W), .FLAG_W(FLAG_W), .ADDR_W(ADDR_W), .LOW_ADDR(LOW_ADDR)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .fieldStrobe (fieldStrobe),
    .errFlags    (errFlags),
    .sensMask    (sensMask),
    .hostRdAddr  (hostRdAddr),
    .hostRdData  (hostRdData),
    .countQ      (count)
  );

  assign mode = modeQ;

endmodule

// File: rtl/err_field_counter_chk.sv
module err_field_counter_chk #(
  parameter int CNT_W    = 24,
  parameter int FLAG_W   = 15,
  parameter int ADDR_W   = 8,
  parameter int LOW_ADDR = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              fieldStrobe,
  input logic [FLAG_W-1:0] errFlags,
  input logic [FLAG_W-1:0] sensMask,
  input logic              modeWrEn,
  input logic              hostRdEn,
  input logic [ADDR_W-1:0] hostRdAddr,
  input logic [CNT_W-1:0]  count,
  input logic [1:0]        mode
);

  localparam logic [CNT_W-1:0] CntMax = '1;

  // R1
  reset_state_chk: assert property (@(posedge clk) !rstN |=> (count == '0 && mode == 2'b00));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ({1'b0, count} <= {1'b0, $past(count)} + 1'b1));

  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && (!fieldStrobe || (errFlags & sensMask) == '0)) |=> $stable(count));

  // R4
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && count == CntMax) |=> count == CntMax);

  // R5
  oneshot_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01) |=> count == '0);

  // R5
  oneshot_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && !modeWrEn) |=> mode == 2'b00);

  // R6
  rdclr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 && hostRdEn && hostRdAddr == ADDR_W'(LOW_ADDR)) |=> count == '0);

  // R8
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11) |=> count == '0);

endmodule

bind err_field_counter err_field_counter_chk #(
  .CNT_W(CNT_W), .FLAG_W(FLAG_W), .ADDR_W(ADDR_W), .LOW_ADDR(LOW_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .fieldStrobe(fieldStrobe), .errFlags(errFlags),
  .sensMask(sensMask), .modeWrEn(modeWrEn), .hostRdEn(hostRdEn),
  .hostRdAddr(hostRdAddr), .count(count), .mode(mode)
);

// File: tb/err_field_counter_tb.sv
`timescale 1ns/1ps
module err_field_counter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fieldStrobe = 1'b0;
  logic [14:0] errFlags = '0;
  logic [14:0] sensMask = '0;
  logic        modeWrEn = 1'b0;
  logic [1:0]  modeWrData = '0;
  logic        hostRdEn = 1'b0;
  logic [7:0]  hostRdAddr = '0;
  logic [7:0]  hostRdData, satRdData;
  logic [23:0] count;
  logic [7:0]  satCount;
  logic [1:0]  mode, satMode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  err_field_counter u_dut (
    .clk(clk), .rstN(rstN), .fieldStrobe(fieldStrobe), .errFlags(errFlags),
    .sensMask(sensMask), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .hostRdEn(hostRdEn), .hostRdAddr(hostRdAddr), .hostRdData(hostRdData),
    .count(count), .mode(mode)
  );

  err_field_counter #(.CNT_W(8)) u_sat (
    .clk(clk), .rstN(rstN), .fieldStrobe(fieldStrobe), .errFlags(errFlags),
    .sensMask(sensMask), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .hostRdEn(hostRdEn), .hostRdAddr(hostRdAddr), .hostRdData(satRdData),
    .count(satCount), .mode(satMode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic field(input logic [14:0] f, input logic [14:0] m);
    fieldStrobe = 1'b1; errFlags = f; sensMask = m;
    @(negedge clk);
    fieldStrobe = 1'b0; errFlags = '0; sensMask = '0;
  endtask

  task automatic writeMode(input logic [1:0] m);
    modeWrEn = 1'b1; modeWrData = m;
    @(negedge clk);
    modeWrEn = 1'b0;
  endtask

  // read with the data checked in the same cycle
  task automatic hostRead(input logic [7:0] a, input logic [7:0] exp, input string tag);
    hostRdEn = 1'b1; hostRdAddr = a;
    #1 check(tag, hostRdData, exp);
    @(negedge clk);
    hostRdEn = 1'b0; hostRdAddr = '0;
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check("R1 count", count, 0);
    check("R1 mode", mode, 0);
  endtask

  task automatic t_count;
    field(15'h0001, 15'h0001);
    check("R2 single flag", count, 1);
    field(15'h7FFF, 15'h7FFF);
    check("R2 many flags", count, 2);
    field(15'h4000, 15'h4000);
    check("R2 top flag", count, 3);
  endtask

  task automatic t_mask;
    field(15'h00FF, 15'h7F00);
    check("R3 masked out", count, 3);
    field(15'h0000, 15'h7FFF);
    check("R3 no flags", count, 3);
    errFlags = 15'h7FFF; sensMask = 15'h7FFF;
    repeat (3) @(negedge clk);
    errFlags = '0; sensMask = '0;
    check("R3 no strobe", count, 3);
  endtask

  task automatic t_oneshot;
    writeMode(2'b01);
    check("R5 mode visible", mode, 1);
    @(negedge clk);
    check("R5 cleared", count, 0);
    check("R5 mode back", mode, 0);
    field(15'h0010, 15'h0010);
    check("R5 resumes", count, 1);
  endtask

  task automatic t_readmap;
    repeat (299) field(15'h0002, 15'h0006);
    check("R2 count 300", count, 300);
    hostRead(8'd17, 8'h2C, "R9 low byte");
    hostRead(8'd18, 8'h01, "R9 mid byte");
    hostRead(8'd19, 8'h00, "R9 high byte");
    hostRead(8'd20, 8'h00, "R9 other addr");
    check("R6 mode00 read no clear", count, 300);
  endtask

  task automatic t_rdclr;
    writeMode(2'b10);
    field(15'h0100, 15'h0100);
    check("R6 counts", count, 301);
    hostRead(8'd18, 8'h01, "R9 mid in rdclr");
    check("R6 mid read no clear", count, 301);
    hostRead(8'd17, 8'h2D, "R9 low in rdclr");
    check("R6 low read clears", count, 0);
    field(15'h0001, 15'h0001);
    check("R6 counts again", count, 1);
  endtask

  task automatic t_race;
    hostRdEn = 1'b1; hostRdAddr = 8'd17;
    fieldStrobe = 1'b1; errFlags = 15'h0001; sensMask = 15'h0001;
    @(negedge clk);
    hostRdEn = 1'b0; fieldStrobe = 1'b0; errFlags = '0; sensMask = '0;
    check("R7 clear wins", count, 0);
  endtask

  task automatic t_hold;
    writeMode(2'b00);
    field(15'h0001, 15'h0001);
    field(15'h0001, 15'h0001);
    check("R8 pre", count, 2);
    writeMode(2'b11);
    check("R8 mode", mode, 3);
    field(15'h0001, 15'h0001);
    field(15'h7FFF, 15'h7FFF);
    check("R8 held zero", count, 0);
    check("R8 mode stays", mode, 3);
    writeMode(2'b00);
    field(15'h0001, 15'h0001);
    check("R8 released", count, 1);
  endtask

  task automatic t_modewr;
    writeMode(2'b01);
    writeMode(2'b10);
    check("R10 write beats return", mode, 2);
    check("R10 cleared", count, 0);
    writeMode(2'b00);
    check("R10 plain write", mode, 0);
  endtask

  task automatic t_sat;
    writeMode(2'b11);
    writeMode(2'b00);
    check("R4 start", satCount, 0);
    repeat (300) field(15'h0400, 15'h0400);
    check("R4 saturated", satCount, 8'hFF);
    check("R4 wide no sat", count, 300);
    hostRdEn = 1'b1; hostRdAddr = 8'd17;
    #1 check("R9 narrow low byte", satRdData, 8'hFF);
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_count();
    t_mask();
    t_oneshot();
    t_readmap();
    t_rdclr();
    t_race();
    t_hold();
    t_modewr();
    t_sat();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule